// File: doc/BRIEF.md
# DMA Channel Event Interrupt Aggregator

This block gathers completion events from a configurable number of DMA channels (8 to 16) and folds them into one interrupt line. Every channel reports three kinds of single-cycle pulse: half of a package moved, a whole package moved, and the complete descriptor chain finished. Each pulse latches a pending flag. Software reaches the flags and their enables through a small 32-bit register port.

Channels are packed four bits each into 32-bit words. Channels 0 to 7 live in the first word of each kind, and channels 8 to 15 live in the second. The second word of each kind only answers when more than eight channels are built. Pending flags are cleared by writing ones. The interrupt output is the registered OR of every pending flag that has its enable set.

Top module: `dma_evt_irq_agg`

## Requirements
- R1: After reset every enable flag and every pending flag is zero, all register words read zero and `irq_o` is low.
- R2: A write to an enable word (offset 0x000 for channels 0-7, 0x004 for channels 8-15) stores bits 0-2 of each 4-bit channel field. Bit 3 of every field reads zero, and the fields of channels that are not built read zero.
- R3: A pulse on `evt_half_i[n]`, `evt_pkg_i[n]` or `evt_list_i[n]` sets bit 0, 1 or 2 of channel n's field. The field sits at bits [4n+3:4n] of the pending word at 0x010 for n < 8, and at bits [4(n-8)+3:4(n-8)] of the pending word at 0x014 for n >= 8. The flag reads back one cycle after the pulse.
- R4: A pending flag is set by its pulse whatever its enable holds. A flag whose enable is zero never raises `irq_o`.
- R5: A write to a pending word clears each flag whose data bit is one and leaves the flags whose data bit is zero. Writing back the value just read clears all of them.
- R6: When a pulse and a clearing write hit the same flag in the same cycle, the flag stays set.
- R7: `irq_o` equals the OR over all channels of (pending AND enable) as it stood one cycle earlier.
- R8: Reads of any other offset return zero, and writes there change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the register word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| evt_half_i | input | NCH | Half-package event pulse per channel |
| evt_pkg_i | input | NCH | Package-complete event pulse per channel |
| evt_list_i | input | NCH | Chain-complete event pulse per channel |
| irq_o | output | 1 | Combined interrupt |

## Verification
An event pulse that sets a pending flag and a software write that clears the same flag can fall in the same cycle. The bench provokes this directly: it writes a clearing one to channel 0's half flag while pulsing that same event, and it then reads the flag back, which must still be set. The long random phase also produces such collisions by chance. There, events and clearing writes to the pending words are drawn independently each cycle. Every read is compared against a model that applies the clear first and the event second, and the interrupt line is compared against the model each cycle.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned FIELD_W     = 4;
    localparam int unsigned CH_PER_WORD = DATA_W / FIELD_W;
    localparam int unsigned MAX_WORDS   = 2;
    localparam int unsigned EN_OFF      = 32'h000;
    localparam int unsigned PEND_OFF    = 32'h010;
    localparam int unsigned WORD_STEP   = 4;

    // one flag per event kind, bit 0 = half, bit 1 = package, bit 2 = chain
    typedef struct packed {
        logic list;
        logic pkg;
        logic half;
    } evt_t;
endpackage

// File: rtl/irqagg_slice.sv
module irqagg_slice
    import irqagg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  evt_t evt_i,
    input  logic en_we_i,
    input  evt_t en_wdata_i,
    input  logic clr_we_i,
    input  evt_t clr_mask_i,
    output evt_t en_o,
    output evt_t pend_o,
    output logic req_o
);
    typedef struct packed {
        evt_t en;
        evt_t pend;
    } slice_st_t;

    slice_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_we_i) begin
            st_d.en = en_wdata_i;
        end
        if (clr_we_i) begin
            st_d.pend = evt_t'(st_q.pend & ~clr_mask_i);
        end
        // a pulse wins over a clear in the same cycle
        st_d.pend = evt_t'(st_d.pend | evt_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.en;
    assign pend_o = st_q.pend;
    assign req_o  = |(st_q.en & st_q.pend);
endmodule

// File: rtl/irqagg_decode.sv
module irqagg_decode
    import irqagg_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned NWORDS = 2
) (
    input  logic                                sel_i,
    input  logic                                we_i,
    input  logic [ADDR_W-1:0]                   addr_i,
    input  logic [MAX_WORDS-1:0][DATA_W-1:0]    en_words_i,
    input  logic [MAX_WORDS-1:0][DATA_W-1:0]    pend_words_i,
    output logic [MAX_WORDS-1:0]                en_we_o,
    output logic [MAX_WORDS-1:0]                clr_we_o,
    output logic [DATA_W-1:0]                   rdata_o
);
    always_comb begin
        en_we_o  = '0;
        clr_we_o = '0;
        rdata_o  = '0;
        for (int w = 0; w < int'(NWORDS); w++) begin
            if (addr_i == ADDR_W'(EN_OFF + WORD_STEP * w)) begin
                rdata_o    = en_words_i[w];
                en_we_o[w] = sel_i & we_i;
            end
            if (addr_i == ADDR_W'(PEND_OFF + WORD_STEP * w)) begin
                rdata_o     = pend_words_i[w];
                clr_we_o[w] = sel_i & we_i;
            end
        end
    end
endmodule

// File: rtl/dma_evt_irq_agg.sv
module dma_evt_irq_agg
    import irqagg_pkg::*;
#(
    parameter int unsigned NCH    = 16,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sel_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic [NCH-1:0]    evt_half_i,
    input  logic [NCH-1:0]    evt_pkg_i,
    input  logic [NCH-1:0]    evt_list_i,
    output logic              irq_o
);
    localparam int unsigned NWORDS = (NCH + CH_PER_WORD - 1) / CH_PER_WORD;

    typedef struct packed {
        logic irq;
    } top_st_t;

    evt_t [NCH-1:0]                  evt_ch;
    evt_t [NCH-1:0]                  en_ch;
    evt_t [NCH-1:0]                  pend_ch;
    logic [NCH-1:0]                  req_ch;
    logic [MAX_WORDS-1:0][DATA_W-1:0] en_words;
    logic [MAX_WORDS-1:0][DATA_W-1:0] pend_words;
    logic [MAX_WORDS-1:0]            en_we;
    logic [MAX_WORDS-1:0]            clr_we;
    top_st_t                         st_d, st_q;

    irqagg_decode #(
        .ADDR_W (ADDR_W),
        .NWORDS (NWORDS)
    ) i_decode (
        .sel_i        (sel_i),
        .we_i         (we_i),
        .addr_i       (addr_i),
        .en_words_i   (en_words),
        .pend_words_i (pend_words),
        .en_we_o      (en_we),
        .clr_we_o     (clr_we),
        .rdata_o      (rdata_o)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam int unsigned WI = ch / CH_PER_WORD;
        localparam int unsigned NI = ch % CH_PER_WORD;

        assign evt_ch[ch] = '{list: evt_list_i[ch], pkg: evt_pkg_i[ch], half: evt_half_i[ch]};

        irqagg_slice i_slice (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .evt_i      (evt_ch[ch]),
            .en_we_i    (en_we[WI]),
            .en_wdata_i (evt_t'(wdata_i[NI*FIELD_W +: 3])),
            .clr_we_i   (clr_we[WI]),
            .clr_mask_i (evt_t'(wdata_i[NI*FIELD_W +: 3])),
            .en_o       (en_ch[ch]),
            .pend_o     (pend_ch[ch]),
            .req_o      (req_ch[ch])
        );
    end

    // pack channel fields into register images, reserved bits stay zero
    always_comb begin
        en_words   = '0;
        pend_words = '0;
        for (int ch = 0; ch < int'(NCH); ch++) begin
            en_words[ch / CH_PER_WORD][(ch % CH_PER_WORD) * FIELD_W +: 3]   = en_ch[ch];
            pend_words[ch / CH_PER_WORD][(ch % CH_PER_WORD) * FIELD_W +: 3] = pend_ch[ch];
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^{wdata_i[31], wdata_i[27], wdata_i[23], wdata_i[19],
                            wdata_i[15], wdata_i[11], wdata_i[7], wdata_i[3]};

    always_comb begin
        st_d     = st_q;
        st_d.irq = |req_ch;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
    parameter int unsigned NCH = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             irq_o,
    input logic [3*NCH-1:0] en_flat,
    input logic [3*NCH-1:0] pend_flat,
    input logic [3*NCH-1:0] evt_flat
);
    // R1
    rst_clear_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (en_flat == '0 && pend_flat == '0 && !irq_o));

    // R7
    irq_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == (|($past(en_flat) & $past(pend_flat))));

    // R6
    evt_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_flat & $past(evt_flat)) == $past(evt_flat));

    // R5
    no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_flat & ~$past(pend_flat) & ~$past(evt_flat)) == '0);

    // R4
    irq_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (|$past(en_flat)));
endmodule

bind dma_evt_irq_agg irqagg_chk #(.NCH(NCH)) i_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irq_o     (irq_o),
    .en_flat   (en_ch),
    .pend_flat (pend_ch),
    .evt_flat  (evt_ch)
);

// File: tb/test_dma_evt_irq_agg.sv
`timescale 1ns/1ps
module test_dma_evt_irq_agg;
    localparam int NCH = 16;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        sel = 1'b0, we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NCH-1:0] eh = '0, ep = '0, el = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [2:0] en_m [NCH];
    logic [2:0] pend_m [NCH];
    logic       exp_irq = 1'b0;

    always #2.5 clk = ~clk;

    dma_evt_irq_agg #(.NCH(NCH), .ADDR_W(12)) i_dma_evt_irq_agg (
        .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .evt_half_i(eh), .evt_pkg_i(ep),
        .evt_list_i(el), .irq_o(irq)
    );

    function automatic logic [31:0] img(input bit pend_sel, input int w);
        logic [31:0] r = '0;
        for (int n = 0; n < 8; n++) begin
            if (8 * w + n < NCH) r[4*n +: 3] = pend_sel ? pend_m[8*w+n] : en_m[8*w+n];
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        case (a)
            12'h000: return img(0, 0);
            12'h004: return img(0, 1);
            12'h010: return img(1, 0);
            12'h014: return img(1, 1);
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic s, input logic w, input logic [11:0] a,
                        input logic [31:0] d, input logic [NCH-1:0] h,
                        input logic [NCH-1:0] p, input logic [NCH-1:0] l,
                        input string req);
        @(negedge clk);
        chk({31'b0, irq}, {31'b0, exp_irq}, "R7 irq");
        sel = s; we = w; addr = a; wdata = d; eh = h; ep = p; el = l;
        #1;
        if (s && !w) chk(rdata, exp_rd(a), req);
        @(posedge clk);
        exp_irq = 1'b0;
        for (int ch = 0; ch < NCH; ch++) exp_irq |= |(en_m[ch] & pend_m[ch]);
        for (int ch = 0; ch < NCH; ch++) begin
            if (s && w && a == 12'(4 * (ch / 8))) en_m[ch] = d[4*(ch%8) +: 3];
            if (s && w && a == 12'(16 + 4 * (ch / 8))) pend_m[ch] &= ~d[4*(ch%8) +: 3];
            pend_m[ch] |= {l[ch], p[ch], h[ch]};
        end
    endtask

    task automatic rd(input logic [11:0] a, input string req);
        step(1, 0, a, 0, 0, 0, 0, req);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step(1, 1, a, d, 0, 0, 0, "wr");
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, "idle");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int ch = 0; ch < NCH; ch++) begin en_m[ch] = '0; pend_m[ch] = '0; end
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_ni = 1'b1;
        // R1: reset state
        rd(12'h000, "R1"); rd(12'h004, "R1"); rd(12'h010, "R1"); rd(12'h014, "R1");
        @(negedge clk); chk({31'b0, irq}, 32'h0, "R1 irq");
        // R2: reserved bits read zero
        wr(12'h000, 32'hFFFF_FFFF); rd(12'h000, "R2");
        @(negedge clk); chk(rdata, 32'h7777_7777, "R2 word0");
        wr(12'h004, 32'hFFFF_FFFF); rd(12'h004, "R2");
        wr(12'h000, 0); wr(12'h004, 0);
        // R3/R4: events with enables off
        step(0, 0, 0, 0, 16'h0001, 0, 0, "R3");
        rd(12'h010, "R3");
        @(negedge clk); chk(rdata, 32'h0000_0001, "R3 ch0 half");
        step(0, 0, 0, 0, 0, 0, 16'h0200, "R3");
        step(0, 0, 0, 0, 0, 16'h8000, 0, "R3");
        rd(12'h014, "R3");
        @(negedge clk); chk(rdata, 32'h2000_0040, "R3 ch9 chain ch15 pkg");
        idle(); idle();
        @(negedge clk); chk({31'b0, irq}, 32'h0, "R4 masked");
        // R5: clear by ones, zeros leave flags
        wr(12'h014, 32'h0000_0040); rd(12'h014, "R5");
        @(negedge clk); chk(rdata, 32'h2000_0000, "R5 partial clear");
        wr(12'h014, 32'h0); rd(12'h014, "R5");
        // R6: event and clear in the same cycle
        step(1, 1, 12'h010, 32'h0000_0001, 16'h0001, 0, 0, "R6");
        rd(12'h010, "R6");
        @(negedge clk); chk(rdata, 32'h0000_0001, "R6 collision");
        // R7: enable raises irq one cycle later
        wr(12'h000, 32'h0000_0001); idle();
        @(negedge clk); chk({31'b0, irq}, 32'h1, "R7 raise");
        wr(12'h010, 32'h0000_0001); idle(); idle();
        @(negedge clk); chk({31'b0, irq}, 32'h0, "R7 drop");
        // R8: unmapped offsets
        wr(12'h008, 32'hFFFF_FFFF); rd(12'h008, "R8"); rd(12'h000, "R8");
        wr(12'h018, 32'hFFFF_FFFF); rd(12'h018, "R8"); rd(12'h014, "R8");
        // random phase: R3 R5 R6 R7
        for (int i = 0; i < 4000; i++) begin
            logic [11:0] a;
            logic [31:0] d;
            case ($urandom % 7)
                0: a = 12'h000; 1: a = 12'h004; 2: a = 12'h010; 3: a = 12'h014;
                4: a = 12'h010; 5: a = 12'h014; default: a = 12'h008;
            endcase
            d = $urandom;
            step(1'($urandom), 1'($urandom), a, d,
                 16'($urandom & $urandom & $urandom), 16'($urandom & $urandom & $urandom),
                 16'($urandom & $urandom & $urandom), "R3 R5 R6 random");
        end
        idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule